// File: doc/BRIEF.md
# Transmit FIFO with Programmable Ready Threshold

This block buffers characters between a host bus and a UART serializer for one channel. It holds up to sixteen 8-bit characters. The host writes with a single-cycle push strobe. The serializer takes characters with a single-cycle pop strobe. Each character popped is presented on the following cycle, with its unused upper bits cleared according to the configured character length.

The block reports its fill count, a full flag and an empty flag. It also drives a transmitter-ready status bit. Interrupt arbitration consumes that bit and considers the transmitter only while the bit is 1. A 2-bit trigger setting selects what "ready" means. The reset default of that setting reports ready only when the FIFO is completely drained. The other three settings report ready whenever a minimum number of locations are free. A push into a full FIFO is lost and is recorded in a sticky overflow flag.

Top module: `tx_fifo_thresh`

## Requirements
- R1: After synchronous reset the fill count is 0, `empty`=1, `full`=0, `overflow`=0 and `pop_data`=0. With `trig_sel`=00, `tx_ready`=1.
- R2: Characters leave in the order they were accepted. The character for a pop appears on `pop_data` on the clock edge that samples the pop, and it holds until the next pop.
- R3: `fill_count`, `full` and `empty` change on the edge that samples an accepted push or pop. `full`=1 exactly when the count is 16, and `empty`=1 exactly when the count is 0.
- R4: With `trig_sel`=00, `tx_ready` is 1 only when the fill count is 0.
- R5: With `trig_sel`=01, `tx_ready` is 1 exactly when at least 4 locations are free, which means a fill count of 12 or less.
- R6: With `trig_sel`=10, `tx_ready` is 1 exactly when at least 8 locations are free, which means a fill count of 8 or less.
- R7: With `trig_sel`=11, `tx_ready` is 1 exactly when at least 12 locations are free, which means a fill count of 4 or less.
- R8: `char_len` encodes 00 as 5 bits, 01 as 6 bits, 10 as 7 bits and 11 as 8 bits. Bits of `pop_data` at and above the character length are 0. The setting in effect in the cycle of the pop applies.
- R9: A push sampled while `full`=1 is dropped, and this holds even when a pop is sampled in the same cycle. A dropped push sets `overflow`, which stays 1 until reset.
- R10: A pop sampled while `empty`=1 yields `pop_data`=0 and leaves the fill count unchanged. A push in that same cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Write strobe from host |
| push_data | input | 8 | Character to store |
| pop | input | 1 | Read strobe from serializer |
| char_len | input | 2 | Character length select |
| trig_sel | input | 2 | Ready trigger select |
| pop_data | output | 8 | Popped character, masked |
| fill_count | output | 5 | Number of stored characters |
| full | output | 1 | FIFO holds 16 characters |
| empty | output | 1 | FIFO holds nothing |
| tx_ready | output | 1 | Transmitter-ready status |
| overflow | output | 1 | Sticky dropped-push flag |

## Verification
The bench sweeps the FIFO from empty to full and back under every trigger setting. It compares `tx_ready` at each fill level, so a threshold that is off by one, or a default setting that signals ready at a partial fill, shows up at the exact count where it goes wrong. The bench pushes into a full FIFO, both alone and together with a pop. A design that accepts either push would corrupt the order or lose the overflow flag. The bench also pops an empty FIFO and pushes all-ones bytes under each short character length, which exposes stale output data, count underflow and masks that keep upper bits.

// File: rtl/tfq_pkg.sv
package tfq_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        TRIG_EMPTY  = 2'b00,
        TRIG_FREE4  = 2'b01,
        TRIG_FREE8  = 2'b10,
        TRIG_FREE12 = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        LEN5 = 2'b00,
        LEN6 = 2'b01,
        LEN7 = 2'b10,
        LEN8 = 2'b11
    } clen_e;

    typedef struct packed {
        logic push_ok;
        logic pop_ok;
    } xfer_t;

    function automatic logic [DATA_W-1:0] len_mask(clen_e len);
        case (len)
            LEN5:    return 8'h1F;
            LEN6:    return 8'h3F;
            LEN7:    return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction

    // free slots required for ready; quarter steps of the depth
    function automatic int free_needed(trig_e t, int depth);
        case (t)
            TRIG_FREE4:  return depth / 4;
            TRIG_FREE8:  return depth / 2;
            TRIG_FREE12: return (depth / 4) * 3;
            default:     return depth;
        endcase
    endfunction

endpackage

// File: rtl/tfq_store.sv
module tfq_store
    import tfq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xf,
    input  logic              pop_req,
    input  clen_e             clen,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pop_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (xf.push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            pop_data <= '0;
        end else begin
            if (xf.push_ok) wr_ptr <= nxt(wr_ptr);
            if (xf.pop_ok) begin
                rd_ptr   <= nxt(rd_ptr);
                pop_data <= mem[rd_ptr] & len_mask(clen);
            end else if (pop_req) begin
                pop_data <= '0;
            end
        end
    end

    // R10
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !xf.pop_ok) |=> (pop_data == '0));

    // R8
    len5_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (xf.pop_ok && clen == LEN5) |=> (pop_data[7:5] == 3'b000));

endmodule

// File: rtl/tfq_level.sv
module tfq_level
    import tfq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  xfer_t         xf,
    input  logic          push_req,
    input  logic          pop_req,
    input  trig_e         trig,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          tx_ready,
    output logic          overflow
);
    logic [CW-1:0] free_slots;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            case ({xf.push_ok, xf.pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (push_req && full) overflow <= 1'b1;
        end
    end

    always_comb begin
        full       = (count == CW'(DEPTH));
        empty      = (count == '0);
        free_slots = CW'(DEPTH) - count;
        if (trig == TRIG_EMPTY)
            tx_ready = empty;
        else
            tx_ready = (free_slots >= CW'(free_needed(trig, DEPTH)));
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R4
    default_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (trig == TRIG_EMPTY && xf.push_ok && !xf.pop_ok && $stable(trig)) |=> !tx_ready);

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push_req && !pop_req) |=> (count == $past(count)));

endmodule

// File: rtl/tx_fifo_thresh.sv
module tx_fifo_thresh
    import tfq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [1:0]        char_len,
    input  logic [1:0]        trig_sel,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     fill_count,
    output logic              full,
    output logic              empty,
    output logic              tx_ready,
    output logic              overflow
);
    xfer_t xf;

    always_comb begin
        xf.push_ok = push && !full;
        xf.pop_ok  = pop && !empty;
    end

    tfq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .xf       (xf),
        .pop_req  (pop),
        .clen     (clen_e'(char_len)),
        .wdata    (push_data),
        .pop_data (pop_data)
    );

    tfq_level #(.DEPTH(DEPTH)) u_level (
        .clk      (clk),
        .rst      (rst),
        .xf       (xf),
        .push_req (push),
        .pop_req  (pop),
        .trig     (trig_e'(trig_sel)),
        .count    (fill_count),
        .full     (full),
        .empty    (empty),
        .tx_ready (tx_ready),
        .overflow (overflow)
    );

endmodule

// File: tb/tb_tx_fifo_thresh.sv
module tb_tx_fifo_thresh;

    logic       clk = 1'b0;
    logic       rst;
    logic       push, pop;
    logic [7:0] push_data;
    logic [1:0] char_len, trig_sel;
    logic [7:0] pop_data;
    logic [4:0] fill_count;
    logic       full, empty, tx_ready, overflow;

    int total = 0;
    int bad   = 0;

    logic [7:0] model_q[$];
    logic [7:0] exp_q[$];
    logic       model_ovf;
    logic       pend;

    always #5 clk = ~clk;

    tx_fifo_thresh dut (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
        .char_len(char_len), .trig_sel(trig_sel), .pop_data(pop_data),
        .fill_count(fill_count), .full(full), .empty(empty),
        .tx_ready(tx_ready), .overflow(overflow)
    );

    task automatic check(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] mask_of(logic [1:0] l);
        return 8'hFF >> (3 - l);
    endfunction

    function automatic logic exp_ready(int cnt, logic [1:0] t);
        case (t)
            2'b00:   return cnt == 0;
            2'b01:   return cnt <= 12;
            2'b10:   return cnt <= 8;
            default: return cnt <= 4;
        endcase
    endfunction

    function automatic string ready_req(logic [1:0] t);
        case (t)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // monitor: compares the character produced by the previous pop
    always @(posedge clk) pend <= pop && !rst;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check("R2", 1, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check("R2", int'(pop_data), int'(e));
            end
        end
    end

    // driver: one cycle of stimulus, model update, then level checks
    task automatic step(logic do_push, logic [7:0] d, logic do_pop);
        logic was_full;
        was_full  = (model_q.size() == 16);
        push      = do_push;
        push_data = d;
        pop       = do_pop;
        if (do_pop) begin
            if (model_q.size() == 0) exp_q.push_back(8'h00);
            else exp_q.push_back(model_q.pop_front() & mask_of(char_len));
        end
        if (do_push) begin
            if (was_full) model_ovf = 1'b1;
            else model_q.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        push = 1'b0;
        pop  = 1'b0;
        check("R3", int'(fill_count), model_q.size());
        check("R3", int'(full),  int'(model_q.size() == 16));
        check("R3", int'(empty), int'(model_q.size() == 0));
        check(ready_req(trig_sel), int'(tx_ready), int'(exp_ready(model_q.size(), trig_sel)));
        check("R9", int'(overflow), int'(model_ovf));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push = 1'b0; pop = 1'b0; push_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_q.delete();
        exp_q.delete();
        model_ovf = 1'b0;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        char_len = 2'b11;
        trig_sel = 2'b00;
        model_ovf = 1'b0;
        do_reset();
        // R1 reset state
        check("R1", int'(fill_count), 0);
        check("R1", int'(empty), 1);
        check("R1", int'(full), 0);
        check("R1", int'(overflow), 0);
        check("R1", int'(pop_data), 0);
        check("R1", int'(tx_ready), 1);

        // R4 fill under default trigger, then overflow (R9)
        for (int i = 0; i < 16; i++) step(1'b1, 8'(8'h30 + i), 1'b0);
        step(1'b1, 8'hEE, 1'b0);
        step(1'b1, 8'hDD, 1'b1);
        for (int i = 0; i < 15; i++) step(1'b0, 8'h00, 1'b1);
        // R10 pop while empty
        step(1'b0, 8'h00, 1'b1);
        step(1'b1, 8'h5A, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        check("R9", int'(overflow), 1);

        // R5 R6 R7 sweeps
        for (int t = 1; t < 4; t++) begin
            trig_sel = 2'(t);
            for (int i = 0; i < 16; i++) step(1'b1, 8'(t * 16 + i), 1'b0);
            for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 1'b1);
        end

        // R8 character length masks
        for (int l = 0; l < 4; l++) begin
            char_len = 2'(l);
            step(1'b1, 8'hFF, 1'b0);
            step(1'b1, 8'hA5, 1'b0);
            step(1'b0, 8'h00, 1'b1);
            step(1'b0, 8'h00, 1'b1);
        end
        char_len = 2'b11;

        // R2 interleaved traffic
        trig_sel = 2'b01;
        for (int i = 0; i < 40; i++) step(1'b1, 8'(i * 7 + 3), (i % 3) != 0);

        step(1'b0, 8'h00, 1'b0);
        do_reset();
        check("R1", int'(overflow), 0);
        check("R1", int'(fill_count), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule